// File: doc/BRIEF.md
# Two-Tier Level and Priority Interrupt Arbiter

This block collects interrupt requests from a parameterised set of software-configured sources and from one hard-wired external pin per interrupt level. It reports a request level and a winning source identifier to the processor. Every configurable source has a level and a sub-priority that orders it among other sources at the same level. Pin source n always sits at level n. Its rank falls between sub-priorities 3 and 4.

The processor supplies its current mask level. The arbiter raises a request only when the best pending level is above that mask. The top level is the exception: it gets through even when the mask is at the top level. When the processor services an interrupt it raises its mask. Because of that, only a strictly higher level can preempt. Sub-priority never preempts; it only picks the order of service inside a level. During the acknowledge cycle the processor names a level. The arbiter answers one clock later with the best pending source at that level, or with a spurious code if nothing at that level is pending.

Top module: `irq_level_arbiter`

## Requirements
- R1: `irq_level` equals the highest level among active sources, or 0 when no source is active. `irq_level`, `win_id` and `irq_req` are registered and follow their inputs one clock later. Level beats sub-priority.
- R2: `irq_req` is 1 when `irq_level` is strictly greater than `mask_level`.
- R3: `irq_req` is 1 whenever `irq_level` is 7, even when `mask_level` is 7.
- R4: `irq_req` is 0 when `irq_level` is between 1 and 6 and not above `mask_level`. This holds whatever the sub-priority of the pending source, so priority never preempts.
- R5: Among the active sources at the winning level, the one with the greatest rank is reported in `win_id`. Configurable source i has rank 2*p, where p is its 3-bit sub-priority. Source ids are: configurable source i is i, pin source n is N_PROG+n-1, and "none" is all ones (15 by default).
- R6: Pin sources have rank 7. A pin beats a configurable source at sub-priority 3 or below on the same level, and loses to one at sub-priority 4 or above.
- R7: When two configurable sources have equal level and sub-priority, the lower index wins.
- R8: A configurable source with level field 0 is disabled and never wins, whatever its pend bit or sub-priority.
- R9: One clock after `ack_valid` is high, `ack_resp_valid` is 1 and `ack_id` holds the best active source at `ack_level`, chosen by R5 to R7. `ack_resp_valid` is 0 in other cycles.
- R10: If no source is active at `ack_level`, `ack_id` returns the spurious code, all ones.
- R11: After reset, `irq_req` is 0, `irq_level` is 0, `win_id` is all ones and `ack_resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_pend | input | N_PROG | Pending bits of configurable sources |
| prog_level | input | N_PROG*3 | Level per configurable source; source i at bits [3i+2:3i] |
| prog_prio | input | N_PROG*3 | Sub-priority per configurable source, same layout |
| pin_pend | input | 7 | Pin requests; bit n-1 is the pin at level n |
| mask_level | input | 3 | Processor's current mask level |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_level | output | 3 | Highest pending level |
| win_id | output | 4 | Winning source id |
| ack_resp_valid | output | 1 | Acknowledge answer valid |
| ack_id | output | 4 | Source id returned for the acknowledge |

## Verification
The hardest condition to set up is a rank tie across source kinds at one level. That needs a pin and a configurable source both active at the same level, with the configurable sub-priority exactly 3 or exactly 4. The stimulus table places pin 3 next to source 2 at level 3 with sub-priority 3, then with sub-priority 4. Acknowledge answers are checked in a separate scene. In that scene, sources at several levels are pending at once, so the level being acknowledged differs from the winning level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   // Rank of a pin source: midway between sub-priorities (2^PW/2 - 1) and 2^PW/2
   function automatic int pin_rank(input int pri_w);
      return (1 << pri_w) - 1;
   endfunction

   function automatic int id_width(input int n_src);
      return $clog2(n_src + 1);
   endfunction
endpackage

// File: rtl/irq_src_table.sv
module irq_src_table #(
   parameter int N_PROG = 8,
   parameter int LVL_W  = 3,
   parameter int PRI_W  = 3,
   localparam int NUM_LVL = (1 << LVL_W) - 1,
   localparam int N_SRC   = N_PROG + NUM_LVL,
   localparam int RANK_W  = PRI_W + 1
) (
   input  logic [N_PROG-1:0]             prog_pend,
   input  logic [N_PROG-1:0][LVL_W-1:0]  prog_level,
   input  logic [N_PROG-1:0][PRI_W-1:0]  prog_prio,
   input  logic [NUM_LVL-1:0]            pin_pend,
   output logic [N_SRC-1:0]              src_act,
   output logic [N_SRC-1:0][LVL_W-1:0]   src_lvl,
   output logic [N_SRC-1:0][RANK_W-1:0]  src_rank
);
   localparam logic [RANK_W-1:0] PIN_RANK = RANK_W'(irq_arb_pkg::pin_rank(PRI_W));

   for (genvar i = 0; i < N_PROG; i++) begin : g_prog
      assign src_act[i]  = prog_pend[i] && (prog_level[i] != '0);
      assign src_lvl[i]  = prog_level[i];
      assign src_rank[i] = {prog_prio[i], 1'b0};
   end

   for (genvar n = 1; n <= NUM_LVL; n++) begin : g_pin
      assign src_act[N_PROG+n-1]  = pin_pend[n-1];
      assign src_lvl[N_PROG+n-1]  = LVL_W'(n);
      assign src_rank[N_PROG+n-1] = PIN_RANK;
   end
endmodule

// File: rtl/irq_max_level.sv
module irq_max_level #(
   parameter int N_SRC = 15,
   parameter int LVL_W = 3
) (
   input  logic [N_SRC-1:0]            src_act,
   input  logic [N_SRC-1:0][LVL_W-1:0] src_lvl,
   output logic [LVL_W-1:0]            max_lvl
);
   always_comb begin
      max_lvl = '0;
      for (int i = 0; i < N_SRC; i++) begin
         if (src_act[i] && (src_lvl[i] > max_lvl)) max_lvl = src_lvl[i];
      end
   end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
   parameter int N_SRC  = 15,
   parameter int LVL_W  = 3,
   parameter int RANK_W = 4,
   parameter int ID_W   = 4
) (
   input  logic [N_SRC-1:0]             src_act,
   input  logic [N_SRC-1:0][LVL_W-1:0]  src_lvl,
   input  logic [N_SRC-1:0][RANK_W-1:0] src_rank,
   input  logic [LVL_W-1:0]             target,
   output logic [ID_W-1:0]              pick_id
);
   logic              found;
   logic [RANK_W-1:0] best;

   // strict greater-than keeps the lowest index on equal ranks
   always_comb begin
      found   = 1'b0;
      best    = '0;
      pick_id = '1;
      for (int i = 0; i < N_SRC; i++) begin
         if (src_act[i] && (src_lvl[i] == target) &&
             (!found || (src_rank[i] > best))) begin
            found   = 1'b1;
            best    = src_rank[i];
            pick_id = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
   parameter int N_PROG = 8,
   parameter int LVL_W  = 3,
   parameter int PRI_W  = 3,
   localparam int NUM_LVL = (1 << LVL_W) - 1,
   localparam int N_SRC   = N_PROG + NUM_LVL,
   localparam int RANK_W  = PRI_W + 1,
   localparam int ID_W    = irq_arb_pkg::id_width(N_SRC)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_PROG-1:0]       prog_pend,
   input  logic [N_PROG*LVL_W-1:0] prog_level,
   input  logic [N_PROG*PRI_W-1:0] prog_prio,
   input  logic [NUM_LVL-1:0]      pin_pend,
   input  logic [LVL_W-1:0]        mask_level,
   input  logic                    ack_valid,
   input  logic [LVL_W-1:0]        ack_level,
   output logic                    irq_req,
   output logic [LVL_W-1:0]        irq_level,
   output logic [ID_W-1:0]         win_id,
   output logic                    ack_resp_valid,
   output logic [ID_W-1:0]         ack_id
);
   localparam logic [LVL_W-1:0] TOP_LVL = '1;
   localparam logic [ID_W-1:0]  SPUR    = '1;

   if (N_PROG < 1) begin : g_chk_prog
      $error("N_PROG must be at least 1");
   end
   if (LVL_W < 1 || PRI_W < 1) begin : g_chk_w
      $error("LVL_W and PRI_W must be at least 1");
   end

   logic [N_SRC-1:0]             src_act;
   logic [N_SRC-1:0][LVL_W-1:0]  src_lvl;
   logic [N_SRC-1:0][RANK_W-1:0] src_rank;
   logic [LVL_W-1:0]             max_lvl;
   logic [ID_W-1:0]              win_nxt;
   logic [ID_W-1:0]              ack_nxt;
   logic                         req_nxt;

   irq_src_table #(.N_PROG(N_PROG), .LVL_W(LVL_W), .PRI_W(PRI_W)) u_table (
      .prog_pend (prog_pend),
      .prog_level(prog_level),
      .prog_prio (prog_prio),
      .pin_pend  (pin_pend),
      .src_act   (src_act),
      .src_lvl   (src_lvl),
      .src_rank  (src_rank)
   );

   irq_max_level #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_max (
      .src_act(src_act),
      .src_lvl(src_lvl),
      .max_lvl(max_lvl)
   );

   irq_level_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W), .RANK_W(RANK_W), .ID_W(ID_W)) u_win (
      .src_act (src_act),
      .src_lvl (src_lvl),
      .src_rank(src_rank),
      .target  (max_lvl),
      .pick_id (win_nxt)
   );

   irq_level_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W), .RANK_W(RANK_W), .ID_W(ID_W)) u_ack (
      .src_act (src_act),
      .src_lvl (src_lvl),
      .src_rank(src_rank),
      .target  (ack_level),
      .pick_id (ack_nxt)
   );

   assign req_nxt = (max_lvl > mask_level) || (max_lvl == TOP_LVL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req        <= 1'b0;
         irq_level      <= '0;
         win_id         <= SPUR;
         ack_resp_valid <= 1'b0;
         ack_id         <= SPUR;
      end else begin
         irq_req        <= req_nxt;
         irq_level      <= max_lvl;
         win_id         <= win_nxt;
         ack_resp_valid <= ack_valid;
         if (ack_valid) ack_id <= ack_nxt;
      end
   end

   assert_req_above_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((irq_level > $past(mask_level)) || (irq_level == TOP_LVL)));

   assert_top_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level == TOP_LVL) |-> irq_req);

   assert_level_has_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> (win_id != SPUR));

   assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(prog_pend) && $stable(prog_level) && $stable(prog_prio)
       && $stable(pin_pend) && $stable(mask_level))
      |=> ($stable(irq_level) && $stable(win_id) && $stable(irq_req)));

   assert_ack_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack_resp_valid |-> $past(ack_valid));
endmodule

// File: tb/irq_level_arbiter_bench.sv
`timescale 1ns/1ps
module irq_level_arbiter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  prog_pend = '0;
   logic [23:0] prog_level = '0;
   logic [23:0] prog_prio = '0;
   logic [6:0]  pin_pend = '0;
   logic [2:0]  mask_level = '0;
   logic        ack_valid = 1'b0;
   logic [2:0]  ack_level = '0;
   logic        irq_req;
   logic [2:0]  irq_level;
   logic [3:0]  win_id;
   logic        ack_resp_valid;
   logic [3:0]  ack_id;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_level_arbiter u_irq_level_arbiter (
      .clk(clk), .rst_n(rst_n), .prog_pend(prog_pend), .prog_level(prog_level),
      .prog_prio(prog_prio), .pin_pend(pin_pend), .mask_level(mask_level),
      .ack_valid(ack_valid), .ack_level(ack_level), .irq_req(irq_req),
      .irq_level(irq_level), .win_id(win_id), .ack_resp_valid(ack_resp_valid),
      .ack_id(ack_id)
   );

   typedef struct packed {
      logic [7:0]  pend;
      logic [23:0] lvl;
      logic [23:0] pri;
      logic [6:0]  pins;
      logic [2:0]  mask;
      logic        req;
      logic [2:0]  elvl;
      logic [3:0]  eid;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{8'h01, 24'o00000003, 24'o00000002, 7'h00, 3'd0, 1'b1, 3'd3, 4'd0,  4'd2},  // R2 basic
      '{8'h03, 24'o00000033, 24'o00000052, 7'h00, 3'd0, 1'b1, 3'd3, 4'd1,  4'd5},  // R5 priority
      '{8'h06, 24'o00000330, 24'o00000330, 7'h00, 3'd0, 1'b1, 3'd3, 4'd1,  4'd7},  // R7 tie
      '{8'h04, 24'o00000300, 24'o00000300, 7'h04, 3'd0, 1'b1, 3'd3, 4'd10, 4'd6},  // R6 pin over p3
      '{8'h04, 24'o00000300, 24'o00000400, 7'h04, 3'd0, 1'b1, 3'd3, 4'd2,  4'd6},  // R6 p4 over pin
      '{8'h18, 24'o00002000, 24'o00070000, 7'h00, 3'd0, 1'b1, 3'd2, 4'd3,  4'd8},  // R8 disabled
      '{8'h20, 24'o00400000, 24'o00100000, 7'h00, 3'd4, 1'b0, 3'd4, 4'd5,  4'd4},  // R4 masked
      '{8'h20, 24'o00400000, 24'o00100000, 7'h00, 3'd3, 1'b1, 3'd4, 4'd5,  4'd2},  // R2 above mask
      '{8'h40, 24'o07000000, 24'o00000000, 7'h00, 3'd7, 1'b1, 3'd7, 4'd6,  4'd3},  // R3 top level
      '{8'h00, 24'o00000000, 24'o00000000, 7'h40, 3'd7, 1'b1, 3'd7, 4'd14, 4'd3},  // R3 pin 7
      '{8'h00, 24'o00000000, 24'o00000000, 7'h00, 3'd0, 1'b0, 3'd0, 4'd15, 4'd1},  // R1 idle
      '{8'h03, 24'o00000052, 24'o00000007, 7'h01, 3'd1, 1'b1, 3'd5, 4'd1,  4'd1}   // R1 level wins
   };

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 irq_req", int'(irq_req), 0);
      check("R11 irq_level", int'(irq_level), 0);
      check("R11 win_id", int'(win_id), 15);
      check("R11 ack_resp_valid", int'(ack_resp_valid), 0);
      rst_n = 1'b1;
      step();

      for (int v = 0; v < NV; v++) begin
         prog_pend  = TBL[v].pend;
         prog_level = TBL[v].lvl;
         prog_prio  = TBL[v].pri;
         pin_pend   = TBL[v].pins;
         mask_level = TBL[v].mask;
         step();
         check($sformatf("R%0d vec%0d req", TBL[v].rq, v), int'(irq_req), int'(TBL[v].req));
         check($sformatf("R%0d vec%0d level", TBL[v].rq, v), int'(irq_level), int'(TBL[v].elvl));
         check($sformatf("R%0d vec%0d id", TBL[v].rq, v), int'(win_id), int'(TBL[v].eid));
      end

      // R4: highest sub-priority at a level equal to the mask still does not request
      prog_pend = 8'h02; prog_level = 24'o00000030; prog_prio = 24'o00000070;
      pin_pend = 7'h00; mask_level = 3'd3;
      step();
      check("R4 equal-level high priority req", int'(irq_req), 0);

      // R9/R10: acknowledge with several levels pending
      prog_pend  = 8'h23;
      prog_level = 24'o00400033;
      prog_prio  = 24'o00100052;
      pin_pend   = 7'h04;
      mask_level = 3'd0;
      ack_valid = 1'b1; ack_level = 3'd3;
      step();
      check("R9 ack valid", int'(ack_resp_valid), 1);
      check("R9 ack level3 id", int'(ack_id), 1);
      check("R1 winning level with ack", int'(irq_level), 4);
      ack_level = 3'd4;
      step();
      check("R9 ack level4 id", int'(ack_id), 5);
      ack_level = 3'd6;
      step();
      check("R10 ack spurious", int'(ack_id), 15);
      ack_level = 3'd0;
      step();
      check("R10 ack level0 spurious", int'(ack_id), 15);
      ack_valid = 1'b0;
      step();
      check("R9 ack valid drops", int'(ack_resp_valid), 0);

      // R8: disabled source at level 0 with top priority, alone
      prog_pend = 8'h01; prog_level = 24'o0; prog_prio = 24'o7; pin_pend = 7'h00;
      step();
      check("R8 disabled level", int'(irq_level), 0);
      check("R8 disabled id", int'(win_id), 15);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule